// File: doc/BRIEF.md
# Ternary Gated-XNOR Neuron Accumulator

This block evaluates a single neuron of a ternary neural network. Pairs of (weight, activation) arrive one per accepted beat on a valid/ready stream. A start marker opens a neuron and a last marker closes it, so the fan-in is set by the stream itself. Each pair is multiplied with a gated XNOR: a zero in either operand forces a zero product, and otherwise the product is +1 or −1. The signed products are summed. A per-neuron threshold is subtracted from the sum, and the difference goes through a three-level activation whose dead zone is programmable and symmetric around zero.

A mode input switches the neuron to binary operation. In that mode every operand counts as ±1, the product is a plain XNOR and the output is the sign of the adjusted sum. The threshold, dead zone and mode are captured on the start beat and apply to the whole neuron. The result is offered with a valid flag that holds until acknowledged, and a one-cycle done pulse marks its arrival. While a result is pending the input stream is stalled.

Top module: `tnn_neuron`

## Requirements
- R1: Operand codes are 2 bits: 2'b01 is +1, 2'b11 is −1 and 2'b00 is 0. In ternary mode the illegal code 2'b10 is read as 0.
- R2: In ternary mode the product of a pair is 0 when the weight or the activation is 0.
- R3: When both operands are nonzero, the product is +1 if their signs agree and −1 if they differ.
- R4: The sum is cleared on the start beat, so only the current neuron's beats are summed. The threshold captured on the start beat is subtracted from it. The threshold, dead zone and mode inputs are ignored on the beats that follow the start beat.
- R5: In ternary mode the result is +1 when the adjusted sum exceeds the dead zone D, −1 when it is below −D, and 0 when it lies within [−D, D], both ends included.
- R6: In binary mode bit 1 of each code gives its sign (1 means −1, 0 means +1), the product is XNOR, and the result is +1 for an adjusted sum ≥ 0 and −1 otherwise. The result is never 0 in this mode.
- R7: The accumulator does not overflow for any fan-in up to FANIN_MAX (1024) beats, including 1024 beats that all give the same sign.
- R8: The result and the done pulse are registered on the clock edge that accepts the last beat. The done pulse lasts exactly one cycle.
- R9: While a result is pending, in_ready_o is low and no input beat is consumed. The result and its valid flag hold until res_ready_i is sampled high.
- R10: The result output never carries the code 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_mode_i | input | 1 | 1 selects binary XNOR/sign operation; captured on the start beat |
| thresh_i | input | ACC_W | Signed neuron threshold; captured on the start beat |
| dz_i | input | ACC_W | Unsigned dead-zone half-width; captured on the start beat |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat can be accepted |
| in_start_i | input | 1 | First beat of a neuron |
| in_last_i | input | 1 | Final beat of a neuron |
| weight_i | input | 2 | Weight code |
| act_i | input | 2 | Input activation code |
| res_valid_o | output | 1 | Result pending |
| res_ready_i | input | 1 | Result acknowledge |
| res_o | output | 2 | Neuron result code |
| done_o | output | 1 | One-cycle pulse when a result arrives |

## Verification
The accumulator-bound check assumes that no neuron has more than FANIN_MAX accepted beats between start markers. It also assumes that every neuron begins with a start beat, since the binary-mode result check follows the mode captured at the start. The stimulus keeps to both assumptions. Random neurons use at most 24 beats, and the directed full-width runs use exactly 1024. Every neuron the bench issues opens with a start beat. The only stray start beats are offered while the input is stalled, and they must not be taken.

// File: rtl/tnn_pkg.sv
package tnn_pkg;
  typedef enum logic [1:0] {
    TRIT_ZERO = 2'b00,
    TRIT_POS  = 2'b01,
    TRIT_BAD  = 2'b10,
    TRIT_NEG  = 2'b11
  } trit_t;

  function automatic logic trit_nonzero(logic [1:0] c);
    return (c == TRIT_POS) || (c == TRIT_NEG);
  endfunction
endpackage

// File: rtl/tnn_gxnor.sv
module tnn_gxnor (
  input  logic              bin_mode_i,
  input  logic [1:0]        w_i,
  input  logic [1:0]        a_i,
  output logic signed [1:0] prod_o
);
  import tnn_pkg::*;

  logic same_sign;
  logic gate;

  assign same_sign = (w_i[1] == a_i[1]);
  assign gate      = bin_mode_i || (trit_nonzero(w_i) && trit_nonzero(a_i));

  always_comb begin
    if (!gate)          prod_o = 2'sb00;
    else if (same_sign) prod_o = 2'sb01;
    else                prod_o = 2'sb11;
  end
endmodule

// File: rtl/tnn_accum.sv
module tnn_accum #(
  parameter int ACC_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic signed [1:0]       prod_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_nxt_o
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] base;

  assign base      = clr_i ? '0 : acc_q;
  assign acc_nxt_o = base + {{(ACC_W-2){prod_i[1]}}, prod_i};
  assign acc_o     = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/tnn_activate.sv
module tnn_activate #(
  parameter int ACC_W = 12,
  localparam int ADJ_W = ACC_W + 1
) (
  input  logic                    bin_mode_i,
  input  logic signed [ACC_W-1:0] sum_i,
  input  logic signed [ACC_W-1:0] thr_i,
  input  logic        [ACC_W-1:0] dz_i,
  output logic [1:0]              res_o
);
  import tnn_pkg::*;

  logic signed [ADJ_W-1:0] adj;
  logic signed [ADJ_W-1:0] dz_pos;
  logic signed [ADJ_W-1:0] dz_neg;

  // one extra bit so sum minus threshold cannot wrap
  assign adj    = {sum_i[ACC_W-1], sum_i} - {thr_i[ACC_W-1], thr_i};
  assign dz_pos = {1'b0, dz_i};
  assign dz_neg = -dz_pos;

  always_comb begin
    if (bin_mode_i)        res_o = adj[ADJ_W-1] ? TRIT_NEG : TRIT_POS;
    else if (adj > dz_pos) res_o = TRIT_POS;
    else if (adj < dz_neg) res_o = TRIT_NEG;
    else                   res_o = TRIT_ZERO;
  end
endmodule

// File: rtl/tnn_neuron.sv
module tnn_neuron #(
  parameter int FANIN_MAX = 1024,
  localparam int ACC_W = $clog2(FANIN_MAX + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bin_mode_i,
  input  logic [ACC_W-1:0] thresh_i,
  input  logic [ACC_W-1:0] dz_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_start_i,
  input  logic             in_last_i,
  input  logic [1:0]       weight_i,
  input  logic [1:0]       act_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [1:0]       res_o,
  output logic             done_o
);
  logic                    accept, finish;
  logic                    mode_q, mode_eff;
  logic signed [ACC_W-1:0] thr_q, thr_eff;
  logic [ACC_W-1:0]        dz_q, dz_eff;
  logic signed [1:0]       prod;
  logic signed [ACC_W-1:0] acc_q, acc_nxt;
  logic [1:0]              act_res;
  logic                    res_valid_q, done_q;
  logic [1:0]              res_q;

  assign in_ready_o = !res_valid_q;
  assign accept     = in_valid_i && in_ready_o;
  assign finish     = accept && in_last_i;

  // start beat uses live config, later beats the captured copy
  assign mode_eff = in_start_i ? bin_mode_i         : mode_q;
  assign thr_eff  = in_start_i ? $signed(thresh_i)  : thr_q;
  assign dz_eff   = in_start_i ? dz_i               : dz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      thr_q  <= '0;
      dz_q   <= '0;
    end else if (accept && in_start_i) begin
      mode_q <= bin_mode_i;
      thr_q  <= $signed(thresh_i);
      dz_q   <= dz_i;
    end
  end

  tnn_gxnor u_gxnor (
    .bin_mode_i (mode_eff),
    .w_i        (weight_i),
    .a_i        (act_i),
    .prod_o     (prod)
  );

  tnn_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (accept),
    .clr_i     (in_start_i),
    .prod_i    (prod),
    .acc_o     (acc_q),
    .acc_nxt_o (acc_nxt)
  );

  tnn_activate #(.ACC_W(ACC_W)) u_act (
    .bin_mode_i (mode_eff),
    .sum_i      (acc_nxt),
    .thr_i      (thr_eff),
    .dz_i       (dz_eff),
    .res_o      (act_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      done_q      <= 1'b0;
      res_q       <= 2'b00;
    end else begin
      done_q <= finish;
      if (finish) begin
        res_valid_q <= 1'b1;
        res_q       <= act_res;
      end else if (res_ready_i) begin
        res_valid_q <= 1'b0;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_o       = res_q;
  assign done_o      = done_q;
endmodule

// File: rtl/tnn_neuron_chk.sv
module tnn_neuron_chk #(
  parameter int FANIN_MAX = 1024,
  parameter int ACC_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    bin_mode_i,
  input logic                    in_valid_i,
  input logic                    in_ready_o,
  input logic                    in_start_i,
  input logic                    in_last_i,
  input logic                    res_valid_o,
  input logic                    res_ready_i,
  input logic [1:0]              res_o,
  input logic                    done_o,
  input logic signed [ACC_W-1:0] acc_i
);
  logic             acc_ok;
  logic             bin_q;
  logic [ACC_W-1:0] beats_q;
  logic             beat;

  assign beat = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beats_q <= '0;
      bin_q   <= 1'b0;
    end else if (beat) begin
      if (in_start_i) begin
        beats_q <= 1;
        bin_q   <= bin_mode_i;
      end else if (beats_q != '1) begin
        beats_q <= beats_q + 1'b1;
      end
    end
  end

  assign acc_ok = (acc_i <= $signed(beats_q)) && (acc_i >= -$signed(beats_q));

  assert_acc_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(beats_q) <= FANIN_MAX) |-> acc_ok);

  assert_stall_when_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !in_ready_o);

  assert_result_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_o)));

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && in_last_i) |=> (done_o && res_valid_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_legal_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_o != 2'b10));

  assert_binary_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && bin_q) |-> (res_o != 2'b00));
endmodule

bind tnn_neuron tnn_neuron_chk #(.FANIN_MAX(FANIN_MAX), .ACC_W(ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bin_mode_i  (bin_mode_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_start_i  (in_start_i),
  .in_last_i   (in_last_i),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_o       (res_o),
  .done_o      (done_o),
  .acc_i       (acc_q)
);

// File: tb/sim_tnn_neuron.sv
module sim_tnn_neuron;
  localparam int ACC_W = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             bin_mode_i = 1'b0;
  logic [ACC_W-1:0] thresh_i = '0;
  logic [ACC_W-1:0] dz_i = '0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic             in_start_i = 1'b0;
  logic             in_last_i = 1'b0;
  logic [1:0]       weight_i = 2'b00;
  logic [1:0]       act_i = 2'b00;
  logic             res_valid_o;
  logic             res_ready_i = 1'b0;
  logic [1:0]       res_o;
  logic             done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] wv [0:1023];
  logic [1:0] av [0:1023];

  always #2 clk_i = ~clk_i;

  tnn_neuron #(.FANIN_MAX(1024)) u0 (.*);

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int code_val(logic [1:0] c, bit bin);
    if (bin) return c[1] ? -1 : 1;
    case (c)
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] expect_res(int n, bit bin, int thr, int dz);
    int sum = 0;
    int adj;
    for (int i = 0; i < n; i++) sum += code_val(wv[i], bin) * code_val(av[i], bin);
    adj = sum - thr;
    if (bin) return (adj >= 0) ? 2'b01 : 2'b11;
    if (adj > dz) return 2'b01;
    if (adj < -dz) return 2'b11;
    return 2'b00;
  endfunction

  task automatic run_neuron(string req, int n, bit bin, int thr, int dz,
                            bit gaps, int hold, bit junk);
    logic [1:0] e;
    e = expect_res(n, bin, thr, dz);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk_i);
        in_valid_i = 1'b0;
      end
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_start_i = (i == 0);
      in_last_i  = (i == n - 1);
      weight_i   = wv[i];
      act_i      = av[i];
      if (i == 0) begin
        bin_mode_i = bin;
        thresh_i   = thr[ACC_W-1:0];
        dz_i       = dz[ACC_W-1:0];
      end else begin
        // scrambled config after the start beat must be ignored (R4)
        bin_mode_i = ~bin;
        thresh_i   = ACC_W'($urandom);
        dz_i       = ACC_W'($urandom);
      end
    end
    @(negedge clk_i);
    check({req, " R8 done"}, int'(done_o), 1);
    check({req, " R8 valid"}, int'(res_valid_o), 1);
    check({req, " result"}, int'(res_o), int'(e));
    check({req, " R10 code"}, int'(res_o == 2'b10), 0);
    in_valid_i = 1'b0;
    in_start_i = 1'b0;
    in_last_i  = 1'b0;
    for (int h = 0; h < hold; h++) begin
      if (junk) begin
        in_valid_i = 1'b1;
        in_start_i = 1'b1;
        in_last_i  = 1'b1;
        weight_i   = 2'b01;
        act_i      = 2'b01;
        bin_mode_i = 1'b1;
        thresh_i   = '0;
      end
      @(negedge clk_i);
      if (h == 0) check({req, " R8 pulse"}, int'(done_o), 0);
      check({req, " R9 ready"}, int'(in_ready_o), 0);
      check({req, " R9 hold"}, int'(res_o), int'(e));
      check({req, " R9 valid"}, int'(res_valid_o), 1);
    end
    in_valid_i  = 1'b0;
    in_start_i  = 1'b0;
    in_last_i   = 1'b0;
    res_ready_i = 1'b1;
    @(negedge clk_i);
    if (hold == 0) check({req, " R8 pulse"}, int'(done_o), 0);
    check({req, " R9 ack"}, int'(res_valid_o), 0);
    check({req, " R9 ready"}, int'(in_ready_o), 1);
    res_ready_i = 1'b0;
  endtask

  task automatic one(string req, logic [1:0] w, logic [1:0] a, bit bin,
                     int thr, int dz);
    wv[0] = w;
    av[0] = a;
    run_neuron(req, 1, bin, thr, dz, 0, 0, 0);
  endtask

  task automatic fill(int n, logic [1:0] w, logic [1:0] a);
    for (int i = 0; i < n; i++) begin
      wv[i] = w;
      av[i] = a;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R9 reset ready", int'(in_ready_o), 1);
    check("R9 reset valid", int'(res_valid_o), 0);
    check("R8 reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    one("R3 differ", 2'b01, 2'b11, 0, 0, 0);
    one("R3 match neg", 2'b11, 2'b11, 0, 0, 0);
    one("R3 match pos", 2'b01, 2'b01, 0, 0, 0);
    one("R2 zero weight", 2'b00, 2'b01, 0, 0, 0);
    one("R2 zero act", 2'b11, 2'b00, 0, 0, 0);
    one("R1 illegal weight", 2'b10, 2'b01, 0, 0, 0);
    one("R1 illegal act", 2'b11, 2'b10, 0, 0, 0);

    fill(5, 2'b01, 2'b01);
    run_neuron("R5 edge in", 5, 0, 2, 3, 0, 0, 0);
    run_neuron("R5 edge out", 5, 0, 2, 2, 0, 0, 0);
    fill(5, 2'b11, 2'b01);
    run_neuron("R5 neg edge in", 5, 0, -2, 3, 0, 0, 0);
    run_neuron("R5 neg edge out", 5, 0, -2, 2, 0, 0, 0);

    fill(3, 2'b01, 2'b01);
    run_neuron("R4 threshold", 3, 0, 5, 1, 0, 0, 0);
    fill(10, 2'b11, 2'b11);
    run_neuron("R4 prior neuron", 10, 0, 0, 0, 0, 0, 0);
    one("R4 cleared", 2'b00, 2'b00, 0, 0, 0);

    wv[0] = 2'b01; av[0] = 2'b01;
    wv[1] = 2'b01; av[1] = 2'b11;
    wv[2] = 2'b00; av[2] = 2'b00;
    wv[3] = 2'b10; av[3] = 2'b01;
    run_neuron("R6 zero sum", 4, 1, 0, 0, 0, 0, 0);
    run_neuron("R6 below", 4, 1, 1, 0, 0, 0, 0);

    fill(1024, 2'b01, 2'b01);
    run_neuron("R7 full pos", 1024, 0, 1023, 0, 0, 0, 0);
    fill(1024, 2'b01, 2'b11);
    run_neuron("R7 full neg", 1024, 0, -1023, 0, 0, 0, 0);

    fill(6, 2'b11, 2'b01);
    run_neuron("R9 stall junk", 6, 0, 0, 0, 1, 5, 1);
    one("R9 junk dropped", 2'b00, 2'b01, 0, 0, 0);

    for (int k = 0; k < 40; k++) begin
      int n, thr, dz;
      bit bin;
      n   = 1 + int'($urandom % 24);
      bin = 1'($urandom);
      thr = int'($urandom % 41) - 20;
      dz  = int'($urandom % 7);
      for (int i = 0; i < n; i++) begin
        wv[i] = 2'($urandom);
        av[i] = 2'($urandom);
      end
      run_neuron(bin ? "R6 random" : "R5 random", n, bin, thr, dz, 1,
                 int'($urandom % 4), 1'($urandom));
    end

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule